// File: doc/BRIEF.md
# SDRAM read latency and burst sequencer

This block is the device-side data timing engine of a single-data-rate synchronous DRAM model. It holds a mode register, and the register is written by a load-mode command. From that register the block decodes the burst length, the read latency, the operating mode and the write-burst policy. It then times the data bus for every accepted READ and WRITE. READ data leaves through a small internal storage array. The output driver enable leads the data-valid strobe by one clock and trails it by one clock. Each beat reports the column address it carries.

READ data is a stream with a valid strobe (`dq_valid`) and no ready input. A synchronous DRAM data bus cannot stall. The receiver must therefore take a beat on every clock in which `dq_valid` is high. The only way to end a read burst early is to issue a new READ, which replaces it once the new READ's latency has elapsed. WRITE data has no handshake either: `wr_data` is sampled on the command edge and on each following edge of the burst. The control inputs and `mode_illegal` are plain pins.

Top module: `sdram_burst_seq`

## Requirements
- R1: `cmd` encodes 0 as NOP, 1 as READ, 2 as WRITE and 3 as LOAD_MODE. LOAD_MODE stores `mode_word` on its edge. Reset leaves the mode at latency 2, burst length 1, normal mode and burst writes, with `dq_oe`, `dq_valid` and `mode_illegal` all low.
- R2: Mode bits 6:4 select the read latency m: code 010 gives 2 and code 011 gives 3. A READ registered at edge n makes `dq_valid` first high after edge n+m, with `beat_col` equal to the READ's `col_addr`.
- R3: `dq_oe` rises after edge n+m-1, one clock before the first valid beat. `dq_oe` is high whenever `dq_valid` is high.
- R4: Mode bits 2:0 select the burst length: codes 000, 001, 010 and 011 give 1, 2, 4 and 8. Beats appear on consecutive clocks. Beat k has column (col & ~(L-1)) | ((col+k) & (L-1)), so the burst wraps inside its aligned block. Mode bit 3 has no effect.
- R5: `dq_valid` goes low right after the last beat. `dq_oe` stays high for exactly one more clock and then goes low.
- R6: During every valid beat, `rd_data` holds the stored word at `beat_col`. The storage array resets to all zeros.
- R7: When mode bit 9 is 0, a WRITE stores `wr_data` at `col_addr` on its command edge. It then stores the `wr_data` of each following edge at the next burst column, with the same length and wrap order as reads.
- R8: When mode bit 9 is 1, a WRITE stores only the word of its command edge at `col_addr`. `wr_data` on the following edges is ignored, and reads still burst at the programmed length.
- R9: `mode_illegal` is high while any of these holds: mode bits 8:7 are nonzero, the latency code is neither 010 nor 011, or the burst code is above 011.
- R10: While `mode_illegal` is high, READ and WRITE are ignored. No `dq_oe` or `dq_valid` results, and the stored data is unchanged.
- R11: A READ issued during a running burst starts its own latency pipeline. The old burst continues until the new burst's first beat, which replaces it on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command: 0 NOP, 1 READ, 2 WRITE, 3 LOAD_MODE |
| col_addr | input | COL_W | Starting column for READ and WRITE |
| mode_word | input | MODE_W | Mode value stored by LOAD_MODE |
| wr_data | input | DATA_W | Write word for the current write beat |
| dq_oe | output | 1 | Data driver enable |
| dq_valid | output | 1 | Read beat valid strobe (no ready) |
| beat_col | output | COL_W | Column of the current read beat |
| rd_data | output | DATA_W | Read word of the current beat |
| mode_illegal | output | 1 | Stored mode uses a reserved or test setting |

## Verification
The driver-enable assertions assume that a pending read is never cancelled, so every rise of `dq_oe` is followed by valid beats. They also assume the latency is at least two clocks, which only a legal mode word can provide. The wrap check assumes that the mode does not change the block layout of a burst already in flight. The stimulus changes the mode only while the bus is idle. It lets every write burst finish before the next read, and it never reads a column on the same edge that writes it.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int MODE_W = 10;
  localparam int CL_MAX = 3;
  localparam int CLW    = 2;
  localparam int MASK_W = 3;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_READ    = 2'd1,
    CMD_WRITE   = 2'd2,
    CMD_SETMODE = 2'd3
  } seq_cmd_e;

  // mode value after reset: latency 2, burst length 1, normal, burst writes
  localparam logic [MODE_W-1:0] MODE_RESET = 10'h020;

  // next column of a burst that wraps inside a block given by a low-bit mask
  function automatic logic [15:0] wrap_step(input logic [15:0] c, input logic [MASK_W-1:0] m);
    logic [15:0] mm;
    mm = {13'd0, m};
    return (c & ~mm) | ((c + 16'd1) & mm);
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg import sdram_seq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MASK_W-1:0] bl_mask,
  output logic [CLW-1:0]    cl,
  output logic              wr_single,
  output logic              illegal
);

  logic [2:0] bl_code_q;
  logic [2:0] cl_code_q;
  logic [1:0] op_q;
  logic       wbm_q;
  logic       mode_unused;

  assign mode_unused = mode_in[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_code_q <= MODE_RESET[2:0];
      cl_code_q <= MODE_RESET[6:4];
      op_q      <= MODE_RESET[8:7];
      wbm_q     <= MODE_RESET[9];
    end else if (load) begin
      bl_code_q <= mode_in[2:0];
      cl_code_q <= mode_in[6:4];
      op_q      <= mode_in[8:7];
      wbm_q     <= mode_in[9];
    end
  end

  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok     = (bl_code_q[2] == 1'b0);
    cl_ok     = (cl_code_q == 3'b010) || (cl_code_q == 3'b011);
    bl_mask   = bl_ok ? ((3'd1 << bl_code_q[1:0]) - 3'd1) : '0;
    cl        = cl_code_q[1:0];
    wr_single = wbm_q;
    illegal   = !bl_ok || !cl_ok || (op_q != 2'b00);
  end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe import sdram_seq_pkg::*; #(
  parameter int COL_W = 4,
  parameter int DEPTH = CL_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [COL_W-1:0]  issue_col,
  input  logic [MASK_W-1:0] issue_mask,
  input  logic [CLW-1:0]    issue_cl,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic [MASK_W-1:0] burst_mask,
  output logic              launch,
  output logic [COL_W-1:0]  nxt_col
);

  // delay line: slot k holds a read that launches its burst k edges later
  logic [DEPTH-1:0]  st_vld, nv;
  logic [COL_W-1:0]  st_col  [DEPTH];
  logic [COL_W-1:0]  ncol    [DEPTH];
  logic [MASK_W-1:0] st_mask [DEPTH];
  logic [MASK_W-1:0] nmask   [DEPTH];

  genvar g;
  for (g = 0; g < DEPTH; g++) begin : g_slot
    logic              sh_v;
    logic [COL_W-1:0]  sh_c;
    logic [MASK_W-1:0] sh_m;
    logic              take;
    if (g < DEPTH-1) begin : g_mid
      assign sh_v = st_vld[g+1];
      assign sh_c = st_col[g+1];
      assign sh_m = st_mask[g+1];
    end else begin : g_top
      assign sh_v = 1'b0;
      assign sh_c = '0;
      assign sh_m = '0;
    end
    assign take     = issue && (issue_cl == CLW'(g + 1));
    assign nv[g]    = take ? 1'b1 : sh_v;
    assign ncol[g]  = take ? issue_col : sh_c;
    assign nmask[g] = take ? issue_mask : sh_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_col[i]  <= '0;
        st_mask[i] <= '0;
      end
    end else begin
      st_vld <= nv;
      for (int i = 0; i < DEPTH; i++) begin
        st_col[i]  <= ncol[i];
        st_mask[i] <= nmask[i];
      end
    end
  end

  // burst generator
  logic              b_act, b_act_n;
  logic [COL_W-1:0]  b_col, b_col_n;
  logic [MASK_W-1:0] b_left, b_left_n;
  logic [MASK_W-1:0] b_mask, b_mask_n;
  logic              oe_q, oe_n;

  always_comb begin
    b_act_n  = b_act;
    b_col_n  = b_col;
    b_left_n = b_left;
    b_mask_n = b_mask;
    if (st_vld[0]) begin
      b_act_n  = 1'b1;
      b_col_n  = st_col[0];
      b_left_n = st_mask[0];
      b_mask_n = st_mask[0];
    end else if (b_act && (b_left != '0)) begin
      b_col_n  = COL_W'(wrap_step(16'(b_col), b_mask));
      b_left_n = b_left - 1'b1;
    end else begin
      b_act_n = 1'b0;
    end
    // lead: head slot filled; body: burst runs; tail: burst just ended
    oe_n = nv[0] | b_act_n | b_act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_col  <= '0;
      b_left <= '0;
      b_mask <= '0;
      oe_q   <= 1'b0;
    end else begin
      b_act  <= b_act_n;
      b_col  <= b_col_n;
      b_left <= b_left_n;
      b_mask <= b_mask_n;
      oe_q   <= oe_n;
    end
  end

  assign dq_oe      = oe_q;
  assign dq_valid   = b_act;
  assign beat_col   = b_col;
  assign burst_mask = b_mask;
  assign launch     = st_vld[0];
  assign nxt_col    = b_col_n;

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst import sdram_seq_pkg::*; #(
  parameter int COL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic [COL_W-1:0]  issue_col,
  input  logic [MASK_W-1:0] issue_mask,
  input  logic              single,
  output logic              we,
  output logic [COL_W-1:0]  waddr,
  output logic              busy
);

  logic              w_act;
  logic [COL_W-1:0]  w_col;
  logic [MASK_W-1:0] w_left;
  logic [MASK_W-1:0] w_mask;
  logic [MASK_W-1:0] eff_mask;

  assign eff_mask = single ? '0 : issue_mask;
  assign we       = issue_wr | (w_act & ~issue_rd);
  assign waddr    = issue_wr ? issue_col : w_col;
  assign busy     = w_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_act  <= 1'b0;
      w_col  <= '0;
      w_left <= '0;
      w_mask <= '0;
    end else if (issue_wr) begin
      w_act  <= (eff_mask != '0);
      w_col  <= COL_W'(wrap_step(16'(issue_col), eff_mask));
      w_left <= eff_mask;
      w_mask <= eff_mask;
    end else if (issue_rd) begin
      w_act <= 1'b0;
    end else if (w_act) begin
      if (w_left == 3'd1) begin
        w_act <= 1'b0;
      end else begin
        w_left <= w_left - 1'b1;
        w_col  <= COL_W'(wrap_step(16'(w_col), w_mask));
      end
    end
  end

endmodule

// File: rtl/sdram_store.sv
module sdram_store #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << COL_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq import sdram_seq_pkg::*; #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode_illegal
);

  logic [MASK_W-1:0] bl_mask;
  logic [CLW-1:0]    cl;
  logic              wr_single;
  logic              acc_rd, acc_wr, ld_mode;
  logic              rd_launch;
  logic [MASK_W-1:0] rd_mask;
  logic [COL_W-1:0]  rd_addr_nx;
  logic              wr_en, wr_busy;
  logic [COL_W-1:0]  wr_addr;

  assign ld_mode = (cmd == CMD_SETMODE);
  assign acc_rd  = (cmd == CMD_READ)  && !mode_illegal;
  assign acc_wr  = (cmd == CMD_WRITE) && !mode_illegal;

  sdram_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_mode),
    .mode_in   (mode_word),
    .bl_mask   (bl_mask),
    .cl        (cl),
    .wr_single (wr_single),
    .illegal   (mode_illegal)
  );

  sdram_rd_pipe #(.COL_W(COL_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (acc_rd),
    .issue_col  (col_addr),
    .issue_mask (bl_mask),
    .issue_cl   (cl),
    .dq_oe      (dq_oe),
    .dq_valid   (dq_valid),
    .beat_col   (beat_col),
    .burst_mask (rd_mask),
    .launch     (rd_launch),
    .nxt_col    (rd_addr_nx)
  );

  sdram_wr_burst #(.COL_W(COL_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_wr   (acc_wr),
    .issue_rd   (acc_rd),
    .issue_col  (col_addr),
    .issue_mask (bl_mask),
    .single     (wr_single),
    .we         (wr_en),
    .waddr      (wr_addr),
    .busy       (wr_busy)
  );

  sdram_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr_nx),
    .rdata (rd_data)
  );

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk import sdram_seq_pkg::*; #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dq_oe,
  input logic              dq_valid,
  input logic [COL_W-1:0]  beat_col,
  input logic [DATA_W-1:0] rd_data,
  input logic              mode_illegal,
  input logic [MASK_W-1:0] burst_mask,
  input logic              launch,
  input logic              wr_en,
  input logic              wr_busy
);

  logic [COL_W-1:0] blk_mask;
  assign blk_mask = COL_W'(burst_mask);

  // R3
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dq_oe);

  // R3
  oe_leads_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));

  // R5
  oe_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (!$past(dq_valid) && $past(dq_valid, 2)));

  // R4
  wrap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && $past(dq_valid) && !$past(launch))
      |-> ((beat_col & ~blk_mask) == ($past(beat_col) & ~blk_mask)));

  // R10
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_illegal && !wr_busy) |-> !wr_en);

  // R6
  beat_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> !$isunknown({beat_col, rd_data}));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dq_oe        (dq_oe),
  .dq_valid     (dq_valid),
  .beat_col     (beat_col),
  .rd_data      (rd_data),
  .mode_illegal (mode_illegal),
  .burst_mask   (rd_mask),
  .launch       (rd_launch),
  .wr_en        (wr_en),
  .wr_busy      (wr_busy)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  import sdram_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // fields: mode[23:14] col[13:10] latency[9:8] read_len[7:4] write_len[3:0] (0 = no write)
  localparam logic [23:0] VEC [NVEC] = '{
    {10'h020, 4'd5,  2'd2, 4'd1, 4'd1},
    {10'h021, 4'd7,  2'd2, 4'd2, 4'd2},
    {10'h032, 4'd9,  2'd3, 4'd4, 4'd4},
    {10'h033, 4'd3,  2'd3, 4'd8, 4'd8},
    {10'h222, 4'd14, 2'd2, 4'd4, 4'd1},
    {10'h233, 4'd10, 2'd3, 4'd8, 4'd1},
    {10'h02A, 4'd1,  2'd2, 4'd4, 4'd4},
    {10'h023, 4'd6,  2'd2, 4'd8, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = CMD_NOP;
  logic [3:0] col_addr = '0;
  logic [9:0] mode_word = '0;
  logic [7:0] wr_data = '0;
  logic       dq_oe, dq_valid, mode_illegal;
  logic [3:0] beat_col;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col_addr(col_addr), .mode_word(mode_word),
    .wr_data(wr_data), .dq_oe(dq_oe), .dq_valid(dq_valid), .beat_col(beat_col),
    .rd_data(rd_data), .mode_illegal(mode_illegal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wcol(input int c, input int k, input int len);
    return (c & ~(len - 1)) | ((c + k) & (len - 1));
  endfunction

  task automatic load_mode(input logic [9:0] m);
    @(negedge clk);
    cmd = CMD_SETMODE;
    mode_word = m;
    @(negedge clk);
    cmd = CMD_NOP;
  endtask

  task automatic do_write(input int col, input int len_prog, input int len_eff, input int seed);
    @(negedge clk);
    cmd = CMD_WRITE;
    col_addr = col[3:0];
    wr_data = seed[7:0];
    for (int b = 1; b < len_prog; b++) begin
      @(negedge clk);
      cmd = CMD_NOP;
      wr_data = 8'(seed + b);
    end
    @(negedge clk);
    cmd = CMD_NOP;
    for (int b = 0; b < len_eff; b++) model[wcol(col, b, len_prog)] = (seed + b) & 8'hFF;
  endtask

  task automatic do_read(input int col, input int m, input int len);
    @(negedge clk);
    cmd = CMD_READ;
    col_addr = col[3:0];
    for (int j = 0; j <= m + len + 1; j++) begin
      bit eoe, ev;
      int ec;
      @(negedge clk);
      if (j == 0) cmd = CMD_NOP;
      eoe = (j >= m - 1) && (j <= m + len);
      ev  = (j >= m) && (j <= m + len - 1);
      chk(dq_oe == eoe, (j < m) ? "R3 oe lead" : "R5 oe tail", int'(dq_oe), int'(eoe));
      chk(dq_valid == ev, (j <= m) ? "R2 latency" : "R5 valid end", int'(dq_valid), int'(ev));
      if (ev) begin
        ec = wcol(col, j - m, len);
        chk(int'(beat_col) == ec, (j == m) ? "R2 first col" : "R4 wrap order", int'(beat_col), ec);
        chk(int'(rd_data) == model[ec], "R6 read data", int'(rd_data), model[ec]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(dq_oe == 1'b0, "R1 reset oe", int'(dq_oe), 0);
    chk(dq_valid == 1'b0, "R1 reset valid", int'(dq_valid), 0);
    chk(mode_illegal == 1'b0, "R1 reset mode legal", int'(mode_illegal), 0);
    // R1 reset mode reads with latency 2, length 1
    do_read(4, 2, 1);

    // table walk: R7 R8 writes, R2 R4 reads
    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] md;
      int vc, vl, vlen, vw;
      md   = VEC[v][23:14];
      vc   = int'(VEC[v][13:10]);
      vl   = int'(VEC[v][9:8]);
      vlen = int'(VEC[v][7:4]);
      vw   = int'(VEC[v][3:0]);
      load_mode(md);
      chk(mode_illegal == 1'b0, "R1 legal mode load", int'(mode_illegal), 0);
      if (vw != 0) do_write(vc, vlen, vw, 16 * v + 17);
      do_read(vc, vl, vlen);
    end

    // R9 reserved words
    begin
      logic [9:0] bad_modes [5] = '{10'h0A0, 10'h120, 10'h040, 10'h010, 10'h024};
      for (int k = 0; k < 5; k++) begin
        load_mode(bad_modes[k]);
        chk(mode_illegal == 1'b1, "R9 reserved flagged", int'(mode_illegal), 1);
      end
    end

    // R10 commands ignored while flagged
    load_mode(10'h0A0);
    @(negedge clk);
    cmd = CMD_READ;
    col_addr = 4'd2;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      cmd = CMD_NOP;
      chk(dq_oe == 1'b0, "R10 no oe when illegal", int'(dq_oe), 0);
      chk(dq_valid == 1'b0, "R10 no valid when illegal", int'(dq_valid), 0);
    end
    @(negedge clk);
    cmd = CMD_WRITE;
    col_addr = 4'd2;
    wr_data = 8'hEE;
    repeat (4) begin
      @(negedge clk);
      cmd = CMD_NOP;
    end
    load_mode(10'h022);
    chk(mode_illegal == 1'b0, "R10 legal again", int'(mode_illegal), 0);
    do_read(2, 2, 4);

    // R11 read interrupting a read
    load_mode(10'h023);
    @(negedge clk);
    cmd = CMD_READ;
    col_addr = 4'd0;
    for (int j = 0; j <= 15; j++) begin
      bit eoe, ev;
      int ec;
      @(negedge clk);
      if (j == 0) cmd = CMD_NOP;
      if (j == 2) begin
        cmd = CMD_READ;
        col_addr = 4'd8;
      end
      if (j == 3) cmd = CMD_NOP;
      eoe = (j >= 1) && (j <= 13);
      ev  = (j >= 2) && (j <= 12);
      chk(dq_oe == eoe, "R11 oe window", int'(dq_oe), int'(eoe));
      chk(dq_valid == ev, "R11 valid window", int'(dq_valid), int'(ev));
      if (ev) begin
        ec = (j < 5) ? (j - 2) : (8 + j - 5);
        chk(int'(beat_col) == ec, "R11 truncation col", int'(beat_col), ec);
        chk(int'(rd_data) == model[ec], "R11 truncation data", int'(rd_data), model[ec]);
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule